// File: doc/BRIEF.md
# In-Band Control Frame Detector

This block sits on the decimated pixel stream that feeds the LED driver chain and separates register-write frames from picture frames. The host hides driver settings inside an ordinary video frame. The first pixel of such a frame is a header word: an 8-bit sync byte, a 6-bit command and a 10-bit count. When that header is present with the configuration command, the whole frame is treated as control data. Its rows are tagged as configuration, global brightness or calibration traffic according to their row index, and no pixel of the frame reaches the picture path.

A control frame has three sections of 32 rows each. In every section the first two rows carry header words and the remaining 30 rows carry one control word per pixel for each driver. The brightness and calibration sections each begin with their own header, and the block checks it. A bad section header raises a sticky error and suppresses that whole section. Rows after the three sections are dropped. A frame without the sync header passes through unchanged as video.

The caller marks the first pixel of a frame with `sof_i` and the first pixel of each later row with `sol_i`. Each output word appears one cycle after its input pixel, together with a kind code and a header flag that the serial frame builder uses to route it.

Top module: `ctrl_frame_detect`

## Requirements
- R1: After reset, out_valid_o, out_hdr_o and format_err_o are 0 and out_kind_o is 2'b00.
- R2: A frame is a control frame only if its first pixel (sof_i) has bits [23:16] = 8'hE8 and bits [15:10] = 6'b111111. In any other frame, every valid pixel is forwarded one cycle later with out_valid_o=1, out_kind_o=2'b00 and out_hdr_o=0.
- R3: In a control frame, rows 0–31 are emitted with out_kind_o=2'b01 (configuration), rows 32–63 with 2'b10 (global brightness) and rows 64–95 with 2'b11 (calibration).
- R4: In a control frame, out_hdr_o=1 for rows 0, 1, 32, 33, 64 and 65, and 0 for every other row.
- R5: No pixel of a control frame is ever emitted with out_kind_o=2'b00. Rows 96 and above of a control frame are dropped (out_valid_o=0).
- R6: The first pixel of row 32 must carry sync 8'hE8 with command 6'b101010, and the first pixel of row 64 must carry sync 8'hE8 with command 6'b010101. On a mismatch, format_err_o is set and all 32 rows of that section are dropped. The other sections are not affected.
- R7: format_err_o stays at 1 across later frames until reset, and reset clears it.
- R8: Rows are counted by sol_i, and sof_i restarts the count at row 0. Each new frame is classified again, and any section discard from the previous frame is cleared.
- R9: Cycles with pix_valid_i=0 produce out_valid_o=0 and do not advance the row count or change the classification.
- R10: out_data_o equals the input pixel of the previous cycle, unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel present this cycle |
| sof_i | input | 1 | First pixel of a frame |
| sol_i | input | 1 | First pixel of a row after row 0 |
| pix_i | input | 24 | Pixel or header word |
| out_valid_o | output | 1 | Forwarded word present |
| out_data_o | output | 24 | Forwarded word |
| out_kind_o | output | 2 | 00 video, 01 configuration, 10 brightness, 11 calibration |
| out_hdr_o | output | 1 | Word belongs to a header row |
| format_err_o | output | 1 | Sticky section header error |

## Verification
The bench uses the default parameters: 32 rows per section, two header rows per section and a 9-bit saturating row count. With these values the full three-section layout, the drop region from row 96 onward and both section-header checks are reached with one short pixel per row, so each frame takes about a hundred cycles. It sends frames with both section headers good, with a bad command at row 32, and with a bad sync at row 64, and it interleaves them with video frames whose first pixel has a wrong sync or a wrong command. It also inserts idle cycles in the middle of a frame.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam int PIX_W  = 24;
  localparam int NSEC   = 3;
  localparam logic [7:0] HDR_SYNC = 8'hE8;

  localparam logic [1:0] KIND_VIDEO = 2'd0;
  localparam logic [1:0] KIND_CFG   = 2'd1;
  localparam logic [1:0] KIND_BRT   = 2'd2;
  localparam logic [1:0] KIND_CAL   = 2'd3;

  // Command expected in the header that opens each section.
  function automatic logic [5:0] sec_cmd(input int s);
    case (s)
      0:       sec_cmd = 6'b111111;
      1:       sec_cmd = 6'b101010;
      default: sec_cmd = 6'b010101;
    endcase
  endfunction
endpackage

// File: rtl/cfd_row_track.sv
module cfd_row_track #(
  parameter int ROW_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             sol_i,
  output logic [ROW_W-1:0] row_o,
  output logic             first_o
);
  localparam logic [ROW_W-1:0] ROW_MAX = '1;

  logic [ROW_W-1:0] row_q;

  always_comb begin
    if (sof_i)      row_o = '0;
    else if (sol_i) row_o = (row_q == ROW_MAX) ? ROW_MAX : row_q + ROW_W'(1);
    else            row_o = row_q;
  end

  assign first_o = sof_i | sol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      row_q <= '0;
    else if (valid_i) row_q <= row_o;
  end

  p_row_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i) |=> (row_q == '0));
  p_row_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sol_i && !sof_i && row_q != ROW_MAX) |=> (row_q == $past(row_q) + ROW_W'(1)));
  p_row_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i) |=> $stable(row_q));
endmodule

// File: rtl/cfd_hdr_match.sv
module cfd_hdr_match
  import cfd_pkg::*;
(
  input  logic [13:0]     hdr_i,   // pixel bits [23:10]: sync then command
  output logic [NSEC-1:0] hit_o
);
  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    assign hit_o[s] = (hdr_i[13:6] == HDR_SYNC) && (hdr_i[5:0] == sec_cmd(s));
  end
endmodule

// File: rtl/cfd_frame_gate.sv
module cfd_frame_gate
  import cfd_pkg::*;
#(
  parameter int ROW_W    = 9,
  parameter int SEC_ROWS = 32,
  parameter int HDR_ROWS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             first_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [NSEC-1:0]  hit_i,
  output logic             is_ctrl_o,
  output logic             pass_o,
  output logic [1:0]       kind_o,
  output logic             hdr_o,
  output logic             err_o
);
  logic            ctrl_q, err_q;
  logic [NSEC-1:0] bad_q, bad_cur, chk, in_sec, hdr_row;

  assign is_ctrl_o = sof_i ? hit_i[0] : ctrl_q;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    localparam logic [ROW_W-1:0] LO = ROW_W'(s * SEC_ROWS);
    localparam logic [ROW_W-1:0] HI = ROW_W'((s + 1) * SEC_ROWS);
    localparam logic [ROW_W-1:0] HL = ROW_W'(s * SEC_ROWS + HDR_ROWS);

    assign in_sec[s]  = (row_i >= LO) && (row_i < HI);
    assign hdr_row[s] = (row_i < HL);

    if (s == 0) begin : g_first
      // Section 0 header decides the frame type itself.
      assign chk[s]     = 1'b0;
      assign bad_cur[s] = 1'b0;
    end else begin : g_rest
      assign chk[s] = valid_i && is_ctrl_o && first_i && !sof_i && (row_i == LO);
      always_comb begin
        if (sof_i)       bad_cur[s] = 1'b0;
        else if (chk[s]) bad_cur[s] = !hit_i[s];
        else             bad_cur[s] = bad_q[s];
      end
    end
  end

  assign pass_o = |(in_sec & ~bad_cur);
  assign hdr_o  = |(in_sec & hdr_row);

  always_comb begin
    kind_o = KIND_VIDEO;
    for (int s = 0; s < NSEC; s++)
      if (in_sec[s]) kind_o = 2'(s + 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 1'b0;
      bad_q  <= '0;
      err_q  <= 1'b0;
    end else if (valid_i) begin
      ctrl_q <= is_ctrl_o;
      bad_q  <= bad_cur;
      if (|(chk & ~hit_i)) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_discard_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i) |=> (bad_q == '0));
  p_discard_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bad_q) |-> err_q);
endmodule

// File: rtl/ctrl_frame_detect.sv
module ctrl_frame_detect
  import cfd_pkg::*;
#(
  parameter int ROW_W    = 9,
  parameter int SEC_ROWS = 32,
  parameter int HDR_ROWS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic             sof_i,
  input  logic             sol_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             out_valid_o,
  output logic [PIX_W-1:0] out_data_o,
  output logic [1:0]       out_kind_o,
  output logic             out_hdr_o,
  output logic             format_err_o
);
  logic [ROW_W-1:0] row;
  logic             first, is_ctrl, pass, hdr, err;
  logic [NSEC-1:0]  hit;
  logic [1:0]       kind;

  cfd_row_track #(.ROW_W(ROW_W)) u_row (
    .clk_i, .rst_ni,
    .valid_i (pix_valid_i),
    .sof_i, .sol_i,
    .row_o   (row),
    .first_o (first)
  );

  cfd_hdr_match u_match (
    .hdr_i (pix_i[23:10]),
    .hit_o (hit)
  );

  cfd_frame_gate #(.ROW_W(ROW_W), .SEC_ROWS(SEC_ROWS), .HDR_ROWS(HDR_ROWS)) u_gate (
    .clk_i, .rst_ni,
    .valid_i   (pix_valid_i),
    .sof_i,
    .first_i   (first),
    .row_i     (row),
    .hit_i     (hit),
    .is_ctrl_o (is_ctrl),
    .pass_o    (pass),
    .kind_o    (kind),
    .hdr_o     (hdr),
    .err_o     (err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_kind_o  <= KIND_VIDEO;
      out_hdr_o   <= 1'b0;
    end else begin
      out_valid_o <= pix_valid_i && (!is_ctrl || pass);
      if (pix_valid_i) begin
        out_data_o <= pix_i;
        out_kind_o <= is_ctrl ? kind : KIND_VIDEO;
        out_hdr_o  <= is_ctrl && hdr;
      end
    end
  end

  assign format_err_o = err;

  p_out_needs_in_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(pix_valid_i));
  p_hdr_is_ctrl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_hdr_o) |-> (out_kind_o != KIND_VIDEO));
  p_video_on_bad_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && sof_i && pix_i[23:16] != HDR_SYNC) |=>
      (out_valid_o && out_kind_o == KIND_VIDEO && !out_hdr_o));
  p_data_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_data_o == $past(pix_i)));
endmodule

// File: tb/ctrl_frame_detect_bench.sv
module ctrl_frame_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0, sof = 1'b0, sol = 1'b0;
  logic [23:0] pix = '0;
  logic        out_valid, out_hdr, format_err;
  logic [23:0] out_data;
  logic [1:0]  out_kind;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  ctrl_frame_detect u_ctrl_frame_detect (
    .clk_i (clk), .rst_ni (rst_n),
    .pix_valid_i (pix_valid), .sof_i (sof), .sol_i (sol), .pix_i (pix),
    .out_valid_o (out_valid), .out_data_o (out_data), .out_kind_o (out_kind),
    .out_hdr_o (out_hdr), .format_err_o (format_err)
  );

  // {sof, sol, pixel, exp_valid, exp_kind, exp_hdr}
  localparam int NV = 10;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 1'b1, 24'h123456, 1'b1, 2'd0, 1'b0},  // R2 plain video
    {1'b0, 1'b0, 24'hE8FC00, 1'b1, 2'd0, 1'b0},  // R2 header-like word mid row
    {1'b0, 1'b1, 24'hE8FC00, 1'b1, 2'd0, 1'b0},  // R2 header-like row 1
    {1'b1, 1'b0, 24'hE8FC05, 1'b1, 2'd1, 1'b1},  // R3 R4 control frame row 0
    {1'b0, 1'b0, 24'hABCDEF, 1'b1, 2'd1, 1'b1},  // R4 second word of row 0
    {1'b0, 1'b1, 24'hE8FC01, 1'b1, 2'd1, 1'b1},  // R4 row 1
    {1'b0, 1'b1, 24'h001122, 1'b1, 2'd1, 1'b0},  // R4 row 2 data
    {1'b1, 1'b0, 24'hE8A800, 1'b1, 2'd0, 1'b0},  // R2 wrong command -> video
    {1'b1, 1'b0, 24'hE9FC00, 1'b1, 2'd0, 1'b0},  // R2 wrong sync -> video
    {1'b1, 1'b0, 24'hE8FC00, 1'b1, 2'd1, 1'b1}   // R8 reclassified as control
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic px(input logic s_f, input logic s_l, input logic [23:0] d,
                    input logic ev, input logic [1:0] ek, input logic eh, input string tag);
    @(negedge clk);
    pix_valid = 1'b1; sof = s_f; sol = s_l; pix = d;
    @(posedge clk); #1;
    check({tag, " valid"}, 32'(out_valid), 32'(ev));
    if (ev) begin
      check({tag, " kind"}, 32'(out_kind), 32'(ek));
      check({tag, " hdr"},  32'(out_hdr),  32'(eh));
      check({tag, " data R10"}, 32'(out_data), 32'(d));
    end
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    pix_valid = 1'b0; sof = 1'b0; sol = 1'b0; pix = 24'hE8FC00;
    @(posedge clk); #1;
    check(tag, 32'(out_valid), 32'd0);
  endtask

  // One pixel per row, rows 0..99; idle cycle inside row 40 region.
  task automatic send_frame(input logic bad32, input logic bad64, input string tag);
    for (int r = 0; r < 100; r++) begin
      logic [23:0] d;
      logic        ev, eh;
      logic [1:0]  ek;
      d = {8'h5A, 16'(r)};
      if (r == 0)  d = 24'hE8FC00;
      if (r == 32) d = bad32 ? 24'hE8FC00 : 24'hE8A800;
      if (r == 64) d = bad64 ? 24'hE75400 : 24'hE85400;
      ev = (r < 96) && !(bad32 && r >= 32 && r < 64) && !(bad64 && r >= 64 && r < 96);
      ek = 2'((r / 32) + 1);
      eh = (r % 32) < 2;
      px(r == 0, r != 0, d, ev, ek, eh, $sformatf("%s R3 R5 R6 row %0d", tag, r));
      if (r == 40) idle({tag, " R9 idle"});
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", 32'(out_valid), 0);
    check("R1 kind",  32'(out_kind), 0);
    check("R1 hdr",   32'(out_hdr), 0);
    check("R1 err",   32'(format_err), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      px(VEC[i][29], VEC[i][28], VEC[i][27:4], VEC[i][3], VEC[i][2:1], VEC[i][0],
         $sformatf("vec %0d R2 R3 R4", i));

    send_frame(1'b0, 1'b0, "good");
    check("R6 no err on good frame", 32'(format_err), 0);

    send_frame(1'b1, 1'b0, "bad32");
    check("R6 err after bad row 32", 32'(format_err), 1);

    // R7: video frame after error: still forwarded, error stays set
    px(1'b1, 1'b0, 24'h00AA55, 1'b1, 2'd0, 1'b0, "R7 video after err");
    px(1'b0, 1'b1, 24'h010203, 1'b1, 2'd0, 1'b0, "R7 video row 1");
    check("R7 err sticky", 32'(format_err), 1);

    // R8: discard from previous frame cleared, row 64 bad this time
    send_frame(1'b0, 1'b1, "bad64");
    check("R7 err still set", 32'(format_err), 1);

    // R9: idle between sof and next row does not advance rows
    px(1'b1, 1'b0, 24'hE8FC00, 1'b1, 2'd1, 1'b1, "R9 row0");
    idle("R9 gap");
    idle("R9 gap 2");
    px(1'b0, 1'b1, 24'h000777, 1'b1, 2'd1, 1'b1, "R9 row1 still header");
    px(1'b0, 1'b1, 24'h000888, 1'b1, 2'd1, 1'b0, "R9 row2 data");

    @(negedge clk); pix_valid = 1'b0; rst_n = 1'b0;
    @(posedge clk); #1;
    check("R7 reset clears err", 32'(format_err), 0);
    check("R1 valid after reset", 32'(out_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule